// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Back End

This block is the digital back end of a seven-stage pipelined analog-to-digital converter. Each stage quantizer delivers a two-bit code on every sample clock. For any one sample, the stage codes arrive one cycle apart: stage 1 first and stage 7 last. The block delays each code so that all seven codes of a sample meet in the same cycle. It then adds them with overlapping weights, so the redundant bit in each code corrects decision errors in the stage before it. The result is one 8-bit straight offset binary word, held in an output register.

The stage-code input bus is packed. Stage k sits at bits `[2k-1:2k-2]`, so stage 1 occupies the two least significant bits. The block has two output controls:
- An active-low output enable blanks the data bus.
- A power-down input blanks the data bus and also empties a five-bit valid pipeline.

A small controller tracks the valid pipeline with three states:
- `ST_DOWN`: power-down is held.
- `ST_FILL`: the valid pipeline is refilling.
- `ST_RUN`: words are valid.

Its transitions are:
- Reset enters `ST_DOWN`.
- `ST_DOWN` goes to `ST_FILL` when power-down is low at an edge.
- `ST_FILL` goes to `ST_RUN` on the edge that fills the last valid slot.
- Any state returns to `ST_DOWN` when power-down is high at an edge.

Top module: `pipeadc_correct`

## Requirements
- R1: If stage 1's code for a sample is captured at rising edge t, and stage k's code for the same sample is captured at edge t+k-1, the corrected word for that sample appears on `dout_o` just after edge t+6. Stage k is delayed by 7-k registers, and stage 7 is not delayed.
- R2: The corrected word is the sum of the aligned codes. Stage k's code (k = 1 to 7) is weighted by 2^(7-k), so stage 1 counts 64 per step and stage 7 counts 1 per step, and adjacent stages overlap by one bit.
- R3: A sum above 255 saturates at 255 and never wraps. For example, all seven codes equal to 3 give 255.
- R4: The coding is straight offset binary. Codes 1,1,1,1,1,1,2 (stage 1 to stage 7) give mid-scale 128 (8'b1000_0000), all zero codes give 0, and positive full scale is 255.
- R5: While `oe_n_i` is high, `dout_drive_o` is 0 and `dout_o` reads 0. The conversion pipeline and `valid_o` keep running, and the true word returns as soon as `oe_n_i` falls.
- R6: While `pwrdn_i` is high, `dout_drive_o` is 0 and `dout_o` reads 0. After any edge at which `pwrdn_i` is high, `valid_o` is 0.
- R7: `valid_o` rises just after the fifth consecutive rising edge with `pwrdn_i` low. If `pwrdn_i` is high at any of those edges, the count restarts; if it is high on the fifth edge itself, `valid_o` stays 0. Once valid, `valid_o` stays 1 while `pwrdn_i` stays low.
- R8: A synchronous active-low reset clears every delay register, the output word and the valid pipeline. After reset, `dout_o` is 0 and `valid_o` is 0 until R7 is met again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_codes_i | input | 14 | Stage codes, stage k at bits [2k-1:2k-2] |
| pwrdn_i | input | 1 | Power-down: blanks outputs and empties the valid pipeline |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | 8 | Corrected straight offset binary word, 0 when blanked |
| dout_drive_o | output | 1 | High when the data bus is driven |
| valid_o | output | 1 | High when the current word is valid |

## Verification
Two functions can meet on one edge: completing the valid refill and a new power-down request. The bench releases power-down, lets four edges pass, and raises power-down again just before the fifth edge. After that edge it expects `valid_o` to stay low, because power-down takes priority over the refill. A clean release followed by five full edges then shows the flag rising on schedule. Output enable and power-down are also applied in separate phases on a steady pipeline, to show that blanking by enable leaves validity intact while power-down destroys it.

// File: rtl/pipeadc_pkg.sv
package pipeadc_pkg;
    localparam int NUM_STAGES  = 7;
    localparam int CODE_W      = 2;
    localparam int WORD_W      = 8;
    localparam int VALID_DEPTH = 5;

    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/stage_align.sv
module stage_align #(
    parameter int NUM_STAGES = 7,
    parameter int CODE_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STAGES*CODE_W-1:0] codes_i,
    output logic [NUM_STAGES*CODE_W-1:0] aligned_o
);
    // Stage k (index k-1) waits NUM_STAGES-k cycles for the later stages.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        localparam int DEPTH = NUM_STAGES - 1 - s;
        if (DEPTH == 0) begin : g_pass
            assign aligned_o[s*CODE_W +: CODE_W] = codes_i[s*CODE_W +: CODE_W];
        end else begin : g_delay
            logic [CODE_W-1:0] taps [DEPTH];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= codes_i[s*CODE_W +: CODE_W];
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign aligned_o[s*CODE_W +: CODE_W] = taps[DEPTH-1];
        end
    end
endmodule

// File: rtl/code_merge.sv
module code_merge #(
    parameter int NUM_STAGES = 7,
    parameter int CODE_W     = 2,
    parameter int WORD_W     = 8
) (
    input  logic [NUM_STAGES*CODE_W-1:0] aligned_i,
    output logic [WORD_W-1:0]            word_o
);
    localparam int SUM_W    = NUM_STAGES + CODE_W;
    localparam int MAX_WORD = (1 << WORD_W) - 1;

    logic [SUM_W-1:0] raw_sum;

    // Each stage sits one bit lower than its predecessor; overlapping bits add.
    always_comb begin
        raw_sum = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            raw_sum = raw_sum
                    + (SUM_W'(aligned_i[s*CODE_W +: CODE_W]) << (NUM_STAGES - 1 - s));
        end
    end

    always_comb begin
        if (raw_sum > SUM_W'(MAX_WORD)) word_o = WORD_W'(MAX_WORD);
        else                            word_o = raw_sum[WORD_W-1:0];
    end
endmodule

// File: rtl/valid_ctrl.sv
module valid_ctrl
    import pipeadc_pkg::*;
#(
    parameter int VALID_DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn_i,
    output logic valid_o
);
    pwr_state_e             state_q, state_d;
    logic [VALID_DEPTH-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN: if (!pwrdn_i) state_d = ST_FILL;
            ST_FILL: begin
                if (pwrdn_i)                        state_d = ST_DOWN;
                else if (fill_q[VALID_DEPTH-2])     state_d = ST_RUN;
            end
            ST_RUN:  if (pwrdn_i) state_d = ST_DOWN;
            default: state_d = ST_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pwrdn_i) fill_q <= '0;
        else                   fill_q <= {fill_q[VALID_DEPTH-2:0], 1'b1};
    end

    always_comb valid_o = fill_q[VALID_DEPTH-1];

    p_pwrdn_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_i |=> !valid_o);
    p_run_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> valid_o);
    p_fill_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !valid_o);
    p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !pwrdn_i) |=> valid_o);
endmodule

// File: rtl/pipeadc_correct.sv
module pipeadc_correct
    import pipeadc_pkg::*;
#(
    parameter int N_STAGES  = NUM_STAGES,
    parameter int C_W       = CODE_W,
    parameter int W_W       = WORD_W,
    parameter int V_DEPTH   = VALID_DEPTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_STAGES*C_W-1:0] stage_codes_i,
    input  logic                   pwrdn_i,
    input  logic                   oe_n_i,
    output logic [W_W-1:0]         dout_o,
    output logic                   dout_drive_o,
    output logic                   valid_o
);
    localparam int BUS_W = N_STAGES * C_W;

    logic [BUS_W-1:0] aligned;
    logic [W_W-1:0]   merged;
    logic [W_W-1:0]   word_q;

    stage_align #(.NUM_STAGES(N_STAGES), .CODE_W(C_W)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .codes_i   (stage_codes_i),
        .aligned_o (aligned)
    );

    code_merge #(.NUM_STAGES(N_STAGES), .CODE_W(C_W), .WORD_W(W_W)) u_merge (
        .aligned_i (aligned),
        .word_o    (merged)
    );

    valid_ctrl #(.VALID_DEPTH(V_DEPTH)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn_i (pwrdn_i),
        .valid_o (valid_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= merged;
    end

    assign dout_drive_o = !oe_n_i && !pwrdn_i;
    assign dout_o       = dout_drive_o ? word_q : '0;

    p_full_scale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned == {BUS_W{1'b1}}) |=> (word_q == {W_W{1'b1}}));
    p_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned == '0) |=> (word_q == '0));
endmodule

// File: tb/pipeadc_correct_test.sv
`timescale 1ns/1ps
module pipeadc_correct_test;
    localparam int NS  = 7;
    localparam int NSM = 600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [13:0]   stage_codes = '0;
    logic          pwrdn = 1'b0;
    logic          oe_n = 1'b0;
    logic [7:0]    dout;
    logic          drive;
    logic          valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [1:0] smp [NSM][NS];

    always #2 clk = ~clk;

    pipeadc_correct uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .stage_codes_i (stage_codes),
        .pwrdn_i       (pwrdn),
        .oe_n_i        (oe_n),
        .dout_o        (dout),
        .dout_drive_o  (drive),
        .valid_o       (valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int exp_word(input int s);
        int sum = 0;
        for (int k = 0; k < NS; k++) sum += int'(smp[s][k]) << (NS - 1 - k);
        return (sum > 255) ? 255 : sum;
    endfunction

    function automatic logic [13:0] all_codes(input logic [1:0] c);
        logic [13:0] v;
        for (int k = 0; k < NS; k++) v[2*k +: 2] = c;
        return v;
    endfunction

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Build sample set: every word by greedy decomposition, then redundant and overrange codes.
        for (int s = 0; s < NSM; s++) begin
            if (s < 256) begin
                int rem = s;
                for (int k = 0; k < NS - 1; k++) begin
                    int w = 1 << (NS - 1 - k);
                    int c = rem / w;
                    if (c > 2) c = 2;
                    smp[s][k] = 2'(c);
                    rem -= c * w;
                end
                smp[s][NS-1] = 2'(rem);
            end else if (s < 500) begin
                for (int k = 0; k < NS; k++) smp[s][k] = 2'($urandom_range(0, 2));
            end else begin
                for (int k = 0; k < NS; k++) smp[s][k] = 2'($urandom_range(0, 3));
            end
        end
        for (int k = 0; k < NS; k++) begin
            smp[256][k] = (k == NS - 1) ? 2'd2 : 2'd1;
            smp[257][k] = 2'd3;
            smp[258][k] = 2'd0;
        end

        // R8: reset state
        repeat (3) edge_step();
        chk("R8 dout after reset", dout, 0);
        chk("R8 valid after reset", valid, 0);
        chk("R5 drive after reset", drive, 1);
        rst_n = 1'b1;

        // R1/R2/R3/R4/R7: staggered stream sweep
        for (int c = 0; c < NSM + 6; c++) begin
            logic [13:0] v;
            for (int k = 0; k < NS; k++) begin
                int idx = c - k;
                v[2*k +: 2] = (idx >= 0 && idx < NSM) ? smp[idx][k] : 2'd0;
            end
            stage_codes = v;
            edge_step();
            chk("R7 valid refill after reset", valid, (c >= 4) ? 1 : 0);
            if (c >= 6 && c - 6 < NSM) begin
                int s = c - 6;
                string tag;
                if (s < 256)       tag = "R1 aligned word";
                else if (s == 256) tag = "R4 mid-scale";
                else if (s == 257) tag = "R3 saturation";
                else if (s == 258) tag = "R4 zero scale";
                else if (s < 500)  tag = "R2 redundant merge";
                else               tag = "R3 overrange";
                chk(tag, dout, exp_word(s));
            end
        end

        // R5: output enable blanking on a steady pipeline (all codes 1 -> 127)
        stage_codes = all_codes(2'd1);
        repeat (8) edge_step();
        chk("R2 steady word", dout, 127);
        oe_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            edge_step();
            chk("R5 dout blanked", dout, 0);
            chk("R5 drive off", drive, 0);
            chk("R5 valid kept", valid, 1);
        end
        oe_n = 1'b0;
        #1;
        chk("R5 word returns", dout, 127);
        chk("R5 drive on", drive, 1);

        // R6: power-down blanks and empties valid
        pwrdn = 1'b1;
        #1;
        chk("R6 dout blanked", dout, 0);
        chk("R6 drive off", drive, 0);
        for (int i = 0; i < 3; i++) begin
            edge_step();
            chk("R6 valid cleared", valid, 0);
        end

        // R7: refill after release
        pwrdn = 1'b0;
        for (int e = 1; e <= 5; e++) begin
            edge_step();
            chk("R7 refill count", valid, (e == 5) ? 1 : 0);
        end
        chk("R6 word after release", dout, 127);

        // R7: power-down on the completing edge wins
        pwrdn = 1'b1;
        edge_step();
        pwrdn = 1'b0;
        for (int e = 1; e <= 4; e++) begin
            edge_step();
            chk("R7 interrupted refill", valid, 0);
        end
        pwrdn = 1'b1;
        edge_step();
        chk("R7 collision keeps invalid", valid, 0);
        pwrdn = 1'b0;
        for (int e = 1; e <= 5; e++) begin
            edge_step();
            chk("R7 second refill", valid, (e == 5) ? 1 : 0);
        end
        for (int i = 0; i < 4; i++) begin
            edge_step();
            chk("R7 valid held", valid, 1);
        end

        // R8: reset mid-stream clears delay lines
        stage_codes = all_codes(2'd3);
        repeat (8) edge_step();
        chk("R3 all-three word", dout, 255);
        rst_n = 1'b0;
        stage_codes = '0;
        edge_step();
        chk("R8 dout in reset", dout, 0);
        chk("R8 valid in reset", valid, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            edge_step();
            chk("R8 delay lines cleared", dout, 0);
        end

        finish_run();
    end
endmodule